// File: doc/BRIEF.md
# Single-Block SHA-1 Compression Coprocessor

This block hashes one 512-bit message block with the SHA-1 compression function. A host on a simple synchronous register bus loads sixteen 32-bit message words. It then pulses a one-clock start input and waits while `busy` is high. Afterwards it reads back the five 32-bit digest words. The host supplies the message words already padded. Each run starts from the standard SHA-1 initial chaining values, and there is no chaining from one block to the next. A synchronous reset is expected before each new load.

The bus uses active-low chip select and active-low write enable, a 5-bit word address, and separate input and output data buses. Read data is registered. A read presented at one rising edge therefore shows up on `dout` just after that edge, and `dout` holds its value until the next read. The bus and the start pin are plain control pins with no handshake. While `busy` is high, bus accesses are dropped and the host must not rely on them.

The engine performs one round per clock over 80 rounds with a rolling 16-word schedule. It spends one further clock adding the working values to the initial values.

Top module: `sha1_block_engine`

## Requirements
- R1: While `rst_n` is low at a rising edge, all message words, all digest words, `busy` and `dout` are cleared to zero.
- R2: Word addresses 0x00 to 0x0F are the message words (0x00 is the most significant word). A write happens when `cs_n` and `we_n` are both low and the engine is idle. A read happens when `cs_n` is low, `we_n` is high and the engine is idle, and it places the word on `dout` after that edge.
- R3: Word addresses 0x10 to 0x14 hold the digest, with 0x10 = H0 (the most significant) through 0x14 = H4. Writes to them are ignored.
- R4: Word addresses 0x15 to 0x1F read as zero, and writes to them are ignored.
- R5: A start pulse sampled while idle raises `busy` at that edge. `busy` is then high for exactly 81 cycles and falls at the edge where the digest words are written.
- R6: A start pulse sampled while `busy` is high is ignored, and the run length is unchanged.
- R7: The digest equals the SHA-1 compression of the 16 message words from the standard initial values, with each result word equal to its initial value plus the final working value modulo 2^32.
- R8: While `busy` is high, writes leave the message words unchanged and reads leave `dout` unchanged.
- R9: `dout` keeps its value in any cycle without a read access, including write cycles and cycles with `cs_n` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 5 | Word address |
| din | input | 32 | Write data |
| dout | output | 32 | Registered read data |
| start | input | 1 | One-clock pulse that begins a run |
| busy | output | 1 | High while a run is in progress |

## Verification
The bench builds the engine with its default 5-bit address. This value puts every decoded region within reach of the bus: the sixteen message words, the five digest words and the eleven unused words up to 0x1F. A behavioural model holding the message words, the digest words, the busy count and the read register is compared with `busy` and `dout` on every clock. The digests are checked against two published SHA-1 results and against a bench-side SHA-1 on pseudo-random blocks. Starts and accesses issued mid-run exercise the busy-time rules.

// File: rtl/sha1_eng_pkg.sv
package sha1_eng_pkg;
  localparam int WORD_W    = 32;
  localparam int MSG_WORDS = 16;
  localparam int RES_WORDS = 5;
  localparam int ROUNDS    = 80;
  localparam int STAGE_LEN = 20;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [RES_WORDS-1:0][WORD_W-1:0] state_t;  // [0]=a .. [4]=e

  function automatic word_t init_val(input int idx);
    case (idx)
      0:       return 32'h67452301;
      1:       return 32'hefcdab89;
      2:       return 32'h98badcfe;
      3:       return 32'h10325476;
      default: return 32'hc3d2e1f0;
    endcase
  endfunction

  function automatic word_t round_const(input int stage);
    case (stage)
      0:       return 32'h5a827999;
      1:       return 32'h6ed9eba1;
      2:       return 32'h8f1bbcdc;
      default: return 32'hca62c1d6;
    endcase
  endfunction

  function automatic word_t mix_fn(input int stage, input word_t b, input word_t c, input word_t d);
    case (stage)
      0:       return (b & c) | (~b & d);
      2:       return (b & c) | (b & d) | (c & d);
      default: return b ^ c ^ d;
    endcase
  endfunction
endpackage

// File: rtl/sha1_sched.sv
module sha1_sched
  import sha1_eng_pkg::*;
#(
  parameter int DEPTH = MSG_WORDS
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load,
  input  logic                         step,
  input  logic [DEPTH-1:0][WORD_W-1:0] load_words,
  output word_t                        w_cur
);
  logic [DEPTH-1:0][WORD_W-1:0] win_q;
  word_t mixed;

  // window holds W[t]..W[t+15]; the new tail is W[t+16]
  assign mixed = win_q[13] ^ win_q[8] ^ win_q[2] ^ win_q[0];
  assign w_cur = win_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q <= '0;
    end else if (load) begin
      win_q <= load_words;
    end else if (step) begin
      for (int i = 0; i < DEPTH - 1; i++) win_q[i] <= win_q[i+1];
      win_q[DEPTH-1] <= {mixed[WORD_W-2:0], mixed[WORD_W-1]};
    end
  end
endmodule

// File: rtl/sha1_round.sv
module sha1_round
  import sha1_eng_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic [CNT_W-1:0] rnd,
  input  state_t           cur,
  input  word_t            w,
  output state_t           nxt
);
  int    stage;
  word_t rot_a;
  word_t temp;

  always_comb begin
    stage = int'(rnd) / STAGE_LEN;
    if (stage > 3) stage = 3;
    rot_a = {cur[0][WORD_W-6:0], cur[0][WORD_W-1:WORD_W-5]};
    temp  = rot_a + mix_fn(stage, cur[1], cur[2], cur[3]) + cur[4] + round_const(stage) + w;
    nxt[0] = temp;
    nxt[1] = cur[0];
    nxt[2] = {cur[1][1:0], cur[1][WORD_W-1:2]};
    nxt[3] = cur[2];
    nxt[4] = cur[3];
  end
endmodule

// File: rtl/sha1_block_engine.sv
module sha1_block_engine
  import sha1_eng_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout,
  input  logic              start,
  output logic              busy
);
  localparam int RES_BASE = MSG_WORDS;
  localparam int RES_END  = RES_BASE + RES_WORDS;
  localparam int CNT_W    = $clog2(ROUNDS + 1);

  logic [MSG_WORDS-1:0][WORD_W-1:0] msg_q;
  state_t                           res_q;
  state_t                           st_q, st_nxt;
  logic [CNT_W-1:0]                 rnd_q;
  logic                             busy_q;
  word_t                            dout_q, rdata, w_cur;
  logic                             acc_ok, wr_en, rd_en, go, fin, step;

  assign acc_ok = !cs_n && !busy_q;
  assign wr_en  = acc_ok && !we_n;
  assign rd_en  = acc_ok && we_n;
  assign go     = start && !busy_q;
  assign fin    = busy_q && (rnd_q == CNT_W'(ROUNDS));
  assign step   = busy_q && !fin;
  assign busy   = busy_q;
  assign dout   = dout_q;

  // message words: writable only while idle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_q <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < MSG_WORDS; i++)
        if (addr == ADDR_W'(i)) msg_q[i] <= din;
    end
  end

  // read decode; unused addresses give zero
  always_comb begin
    rdata = '0;
    for (int i = 0; i < MSG_WORDS; i++)
      if (addr == ADDR_W'(i)) rdata = msg_q[i];
    for (int i = 0; i < RES_WORDS; i++)
      if (addr == ADDR_W'(RES_BASE + i)) rdata = res_q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     dout_q <= '0;
    else if (rd_en) dout_q <= rdata;
  end

  // sequencing: go -> 80 rounds -> finalize
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rnd_q  <= '0;
    end else if (go) begin
      busy_q <= 1'b1;
      rnd_q  <= '0;
    end else if (fin) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      rnd_q  <= rnd_q + 1'b1;
    end
  end

  sha1_sched #(.DEPTH(MSG_WORDS)) u_sched (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (go),
    .step       (step),
    .load_words (msg_q),
    .w_cur      (w_cur)
  );

  sha1_round #(.CNT_W(CNT_W)) u_round (
    .rnd (rnd_q),
    .cur (st_q),
    .w   (w_cur),
    .nxt (st_nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= '0;
    end else if (go) begin
      for (int i = 0; i < RES_WORDS; i++) st_q[i] <= init_val(i);
    end else if (step) begin
      st_q <= st_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (fin) begin
      for (int i = 0; i < RES_WORDS; i++) res_q[i] <= init_val(i) + st_q[i];
    end
  end

  // R5
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(start));

  // R5
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(rnd_q) == CNT_W'(ROUNDS)));

  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !fin) |=> busy_q);

  // R8
  busy_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(msg_q));

  // R3
  res_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(res_q) |-> $fell(busy_q));

  // R4
  unused_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr >= ADDR_W'(RES_END)) |=> (dout_q == '0));

  // R9
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(dout_q));
endmodule

// File: tb/sha1_block_engine_bench.sv
module sha1_block_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n, cs_n, we_n, start;
  logic [4:0]  addr;
  logic [31:0] din, dout;
  logic        busy;
  int          vecs = 0;
  int          miss = 0;
  logic [31:0] v;

  always #4 clk = ~clk;  // 125 MHz

  sha1_block_engine u_sha1_block_engine (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .addr(addr),
    .din(din), .dout(dout), .start(start), .busy(busy)
  );

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic logic [159:0] ref_sha1(input logic [31:0] m[16]);
    logic [31:0] w[80];
    logic [31:0] h[5];
    logic [31:0] a, b, c, d, e, f, k, t;
    h[0] = 32'h67452301; h[1] = 32'hefcdab89; h[2] = 32'h98badcfe;
    h[3] = 32'h10325476; h[4] = 32'hc3d2e1f0;
    for (int i = 0; i < 80; i++)
      w[i] = (i < 16) ? m[i] : rl(w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16], 1);
    a = h[0]; b = h[1]; c = h[2]; d = h[3]; e = h[4];
    for (int i = 0; i < 80; i++) begin
      if (i < 20)      begin f = (b & c) | (~b & d);          k = 32'h5a827999; end
      else if (i < 40) begin f = b ^ c ^ d;                   k = 32'h6ed9eba1; end
      else if (i < 60) begin f = (b & c) | (b & d) | (c & d); k = 32'h8f1bbcdc; end
      else             begin f = b ^ c ^ d;                   k = 32'hca62c1d6; end
      t = rl(a, 5) + f + e + k + w[i];
      e = d; d = c; c = rl(b, 30); b = a; a = t;
    end
    return {h[0] + a, h[1] + b, h[2] + c, h[3] + d, h[4] + e};
  endfunction

  // behavioural cycle model
  logic [31:0] mbuf[16];
  logic [31:0] mres[5];
  logic [31:0] mdout;
  logic        mbusy;
  int          mcnt;
  bit          started = 0;
  string       mtag = "R1";

  always @(posedge clk) begin
    logic [159:0] dg;
    if (!rst_n) begin
      foreach (mbuf[i]) mbuf[i] = '0;
      foreach (mres[i]) mres[i] = '0;
      mdout = '0; mbusy = 1'b0; mcnt = 0; mtag = "R1";
    end else begin
      if (!cs_n && !mbusy) begin
        if (!we_n) begin
          if (addr < 16) mbuf[addr] = din;
        end else if (addr < 16) begin
          mdout = mbuf[addr]; mtag = "R2";
        end else if (addr < 21) begin
          mdout = mres[addr-16]; mtag = "R3";
        end else begin
          mdout = '0; mtag = "R4";
        end
      end
      if (mbusy) begin
        mcnt++;
        if (mcnt == 81) begin
          dg = ref_sha1(mbuf);
          for (int i = 0; i < 5; i++) mres[i] = dg[159-32*i -: 32];
          mbusy = 1'b0;
        end
      end else if (start) begin
        mbusy = 1'b1; mcnt = 0;
      end
    end
    started = 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk("R5 busy model", {31'b0, busy}, {31'b0, mbusy});
      chk({mtag, " dout model"}, dout, mdout);
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    cs_n = 0; we_n = 0; addr = a; din = d;
    @(negedge clk);
    cs_n = 1; we_n = 1;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    cs_n = 0; we_n = 1; addr = a;
    @(negedge clk);
    d = dout;
    cs_n = 1;
  endtask

  task automatic pulse_start();
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic run_block();
    pulse_start();
    while (busy) @(negedge clk);
  endtask

  task automatic check_digest(input string tag, input logic [159:0] exp);
    for (int i = 0; i < 5; i++) begin
      rd(5'(16 + i), v);
      chk(tag, v, exp[159-32*i -: 32]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miss++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    int n;
    logic [31:0] blk[16];
    cs_n = 1; we_n = 1; addr = '0; din = '0; start = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    chk("R1 busy", {31'b0, busy}, 32'h0);
    chk("R1 dout", dout, 32'h0);
    rd(5'd16, v); chk("R1 digest", v, 32'h0);
    rd(5'd3, v);  chk("R1 msg", v, 32'h0);

    // R2: load "abc" padded block
    wr(5'd0, 32'h61626380);
    for (int i = 1; i < 15; i++) wr(5'(i), 32'h0);
    wr(5'd15, 32'h00000018);
    rd(5'd0, v);  chk("R2 word0", v, 32'h61626380);
    rd(5'd15, v); chk("R2 word15", v, 32'h00000018);

    // R5, R6, R8: mid-run start and accesses
    pulse_start();
    chk("R5 busy up", {31'b0, busy}, 32'h1);
    wr(5'd0, 32'hdeadbeef);
    pulse_start();
    rd(5'd0, v); chk("R8 read while busy holds", v, 32'h00000018);
    n = 3;
    while (busy) begin @(negedge clk); n++; end
    chk("R5 busy length", 32'(n), 32'd81);
    chk("R6 restart ignored", 32'(n), 32'd81);
    rd(5'd0, v); chk("R8 write while busy ignored", v, 32'h61626380);

    // R7: known digest
    check_digest("R7 abc", 160'ha9993e364706816aba3e25717850c26c9cd0d89d);

    // R3, R4
    wr(5'd16, 32'h0);
    rd(5'd16, v); chk("R3 digest read-only", v, 32'ha9993e36);
    wr(5'd23, 32'hffffffff);
    rd(5'd23, v); chk("R4 unused reads zero", v, 32'h0);
    rd(5'd31, v); chk("R4 top address", v, 32'h0);

    // R9: hold without reads
    rd(5'd20, v);
    repeat (3) @(negedge clk);
    chk("R9 idle hold", dout, 32'h9cd0d89d);
    wr(5'd5, 32'h12345678);
    chk("R9 write hold", dout, 32'h9cd0d89d);

    // R1 again, then empty-message block
    do_reset();
    rd(5'd16, v); chk("R1 digest cleared", v, 32'h0);
    rd(5'd5, v);  chk("R1 msg cleared", v, 32'h0);
    wr(5'd0, 32'h80000000);
    run_block();
    check_digest("R7 empty", 160'hda39a3ee5e6b4b0d3255bfef95601890afd80709);

    // R7: pseudo-random blocks
    for (int b = 0; b < 3; b++) begin
      do_reset();
      for (int i = 0; i < 16; i++) begin
        blk[i] = $urandom;
        wr(5'(i), blk[i]);
      end
      run_block();
      check_digest("R7 random", ref_sha1(blk));
    end

    repeat (2) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule